// File: doc/BRIEF.md
# SECDED-Protected Dual-Port RAM with Fault Injection

This block is a synchronous simple dual-port RAM: one write port and one read port on a shared clock. Storage is organised in 64-bit data lanes. When protection is on, each lane is held as a 72-bit word: the 64 data bits plus 8 check bits of an extended Hamming code, which corrects single-bit errors and detects double-bit errors.

The parameter `ECC_MODE` picks where the code is applied. In mode 0 there is no protection. In mode 1 the block encodes on the write side and returns the raw 72-bit words. In mode 2 the writer supplies already-encoded 72-bit words and the block decodes on the read side. In mode 3 the block both encodes and decodes. Two write-side inputs corrupt the word being stored so that the error path can be tested. Two read-side flags report whether a read was clean, had a single-bit error that was corrected, or had a double-bit error.

Top module: `ecc_ram`

## Requirements
- R1: Per-lane port widths depend on `ECC_MODE`. Mode 0 writes 64 and reads 64 bits. Mode 1 writes 64 and reads 72. Mode 2 writes 72 and reads 64. Mode 3 writes 64 and reads 64. Lane l occupies bits [l*W +: W] of the port, where W is that port's lane width.
- R2: A 72-bit lane word holds data in [63:0], Hamming bits in [70:64] and overall parity in [71]. Data bits take the codeword positions 3, 5, 6, 7, 9, … in increasing order, skipping powers of two. Hamming bit j is the XOR of the data bits whose position has bit j set. Bit 71 is the XOR of the other 71 bits. For example, data 1 gives check byte 0x83 and data 2 gives 0x85.
- R3: When decoding, a single flipped bit anywhere in a lane's 72 bits is corrected on the read data, with `err_single`=1 and `err_double`=0.
- R4: When decoding, two flipped bits in one lane give `err_double`=1 and `err_single`=0, and the data bits are returned as stored, uncorrected.
- R5: Read data and flags are valid after the clock edge that samples `rd_en`=1 and `rd_addr`. They hold while `rd_en` is low. A read of an address being written on the same edge returns the old contents.
- R6: `inj_single` on a write flips data bit 0 of lane 0 in the stored word.
- R7: `inj_double` on a write flips data bits 0 and 1 of lane 0. When both inputs are high, only the double-bit corruption is applied.
- R8: Correction applies only to the output. A second read of a corrupted address reports the same error again.
- R9: With several lanes, each flag is the OR of the per-lane results.
- R10: In modes 0 and 1 both flags stay 0. In mode 0 the injection inputs have no effect on stored data.
- R11: A synchronous active-high reset clears the read data and both flags to 0 and leaves the memory contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | LANES*WR_LW | Write data (64 or 72 bits per lane) |
| inj_single | input | 1 | Corrupt one bit of the word being written |
| inj_double | input | 1 | Corrupt two bits of the word being written |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | LANES*RD_LW | Read data (64 or 72 bits per lane) |
| err_single | output | 1 | A single-bit error was corrected on this read |
| err_double | output | 1 | An uncorrectable double-bit error was found on this read |

## Verification
A wrong syndrome-to-position mapping shows up on the first read after an injected or hand-flipped bit. It appears as a second flipped data bit or as the wrong flag, one cycle after the read address is sampled. Encoder faults are exposed by passing mode-1 output words, flipped by the bench at chosen positions, into a mode-2 instance: an inconsistent check byte raises a flag on a clean word. A corrupted read register or broken read-first ordering appears on the very next read or during a hold.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CODE_W = 72;

  // Codeword position of data bit idx: positions from 3 upward that are not powers of two
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < 128; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [HAM_W-1:0] ham_parity(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] par;
    int pos;
    par = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pos = data_pos(i);
      for (int j = 0; j < HAM_W; j++)
        if (pos[j]) par[j] = par[j] ^ d[i];
    end
    return par;
  endfunction

endpackage

// File: rtl/ecc_lane_enc.sv
module ecc_lane_enc
  import ecc_ram_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CODE_W-1:0] code_out
);

  logic [HAM_W-1:0] par;

  always_comb begin
    par      = ham_parity(data_in);
    code_out = {^{par, data_in}, par, data_in};
  end

endmodule

// File: rtl/ecc_lane_dec.sv
module ecc_lane_dec
  import ecc_ram_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [DATA_W-1:0] data_out,
  output logic              err_s,
  output logic              err_d
);

  logic [HAM_W-1:0] syn;
  logic             odd;

  always_comb begin
    syn   = ham_parity(code_in[DATA_W-1:0]) ^ code_in[DATA_W +: HAM_W];
    odd   = ^code_in;
    err_s = odd;
    err_d = !odd && (syn != '0);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = data_pos(i);
    assign data_out[i] = code_in[i] ^ (err_s && (syn == HAM_W'(POS)));
  end

endmodule

// File: rtl/ecc_ram_store.sv
module ecc_ram_store #(
  parameter int WIDTH  = 144,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WIDTH-1:0]  wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [WIDTH-1:0]  q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[ra];
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(re)) |-> $stable(q));

endmodule

// File: rtl/ecc_ram.sv
module ecc_ram
  import ecc_ram_pkg::*;
#(
  parameter int ECC_MODE = 3,
  parameter int LANES    = 2,
  parameter int ADDR_W   = 5,
  localparam int WR_LW   = (ECC_MODE == 2) ? CODE_W : DATA_W,
  localparam int RD_LW   = (ECC_MODE == 1) ? CODE_W : DATA_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [LANES*WR_LW-1:0] wr_data,
  input  logic                   inj_single,
  input  logic                   inj_double,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [LANES*RD_LW-1:0] rd_data,
  output logic                   err_single,
  output logic                   err_double
);

  localparam bit ENC_ON   = (ECC_MODE == 1) || (ECC_MODE == 3);
  localparam bit DEC_ON   = (ECC_MODE == 2) || (ECC_MODE == 3);
  localparam int STORE_LW = (ECC_MODE == 0) ? DATA_W : CODE_W;
  localparam int STORE_W  = LANES * STORE_LW;

  logic [STORE_W-1:0] wr_flat;
  logic [STORE_W-1:0] rd_flat;
  logic [LANES-1:0]   lane_s;
  logic [LANES-1:0]   lane_d;
  logic [1:0]         flip;

  // double-bit request wins over single-bit request
  assign flip = inj_double ? 2'b11 : (inj_single ? 2'b01 : 2'b00);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STORE_LW-1:0] mask;
    logic [STORE_LW-1:0] raw;

    if (l == 0 && ECC_MODE != 0) begin : g_inj
      assign mask = {{(STORE_LW-2){1'b0}}, flip};
    end else begin : g_noinj
      assign mask = '0;
    end

    // write side
    if (ENC_ON) begin : g_enc
      logic [CODE_W-1:0] code;
      ecc_lane_enc u_enc (
        .data_in  (wr_data[l*WR_LW +: DATA_W]),
        .code_out (code)
      );
      assign wr_flat[l*STORE_LW +: STORE_LW] = code ^ mask;
    end else begin : g_pass
      assign wr_flat[l*STORE_LW +: STORE_LW] = wr_data[l*WR_LW +: STORE_LW] ^ mask;
    end

    assign raw = rd_flat[l*STORE_LW +: STORE_LW];

    // read side
    if (DEC_ON) begin : g_dec
      logic [DATA_W-1:0] dout;
      ecc_lane_dec u_dec (
        .code_in  (raw),
        .data_out (dout),
        .err_s    (lane_s[l]),
        .err_d    (lane_d[l])
      );
      assign rd_data[l*RD_LW +: RD_LW] = dout;

      // R3
      single_fix_chk: assert property (@(posedge clk) disable iff (rst)
        lane_s[l] |-> ($countones(dout ^ raw[DATA_W-1:0]) <= 1));
      // R4
      double_raw_chk: assert property (@(posedge clk) disable iff (rst)
        lane_d[l] |-> (dout == raw[DATA_W-1:0]));
    end else begin : g_raw
      assign rd_data[l*RD_LW +: RD_LW] = raw;
      assign lane_s[l] = 1'b0;
      assign lane_d[l] = 1'b0;
    end
  end

  if (ECC_MODE == 0) begin : g_unused
    logic unused_inj;
    assign unused_inj = ^flip;
  end

  ecc_ram_store #(
    .WIDTH  (STORE_W),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk (clk),
    .rst (rst),
    .we  (wr_en),
    .wa  (wr_addr),
    .wd  (wr_flat),
    .re  (rd_en),
    .ra  (rd_addr),
    .q   (rd_flat)
  );

  assign err_single = |lane_s;
  assign err_double = |lane_d;

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !err_single && !err_double));
  // R10
  no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !DEC_ON |-> (!err_single && !err_double));

endmodule

// File: tb/tb_ecc_ram.sv
`timescale 1ns/1ps
module tb_ecc_ram;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // full mode (3)
  logic         f_we = 0, f_is = 0, f_id = 0, f_re = 0;
  logic [4:0]   f_wa = '0, f_ra = '0;
  logic [127:0] f_wd = '0;
  logic [127:0] f_q;
  logic         f_s, f_d;
  // encode-only (1)
  logic         e_we = 0, e_is = 0, e_id = 0, e_re = 0;
  logic [4:0]   e_wa = '0, e_ra = '0;
  logic [127:0] e_wd = '0;
  logic [143:0] e_q;
  logic         e_s, e_d;
  // decode-only (2)
  logic         d_we = 0, d_is = 0, d_id = 0, d_re = 0;
  logic [4:0]   d_wa = '0, d_ra = '0;
  logic [143:0] d_wd = '0;
  logic [127:0] d_q;
  logic         d_s, d_d;
  // off (0)
  logic         o_we = 0, o_is = 0, o_id = 0, o_re = 0;
  logic [4:0]   o_wa = '0, o_ra = '0;
  logic [127:0] o_wd = '0;
  logic [127:0] o_q;
  logic         o_s, o_d;

  ecc_ram #(.ECC_MODE(3)) dut (
    .clk(clk), .rst(rst), .wr_en(f_we), .wr_addr(f_wa), .wr_data(f_wd),
    .inj_single(f_is), .inj_double(f_id), .rd_en(f_re), .rd_addr(f_ra),
    .rd_data(f_q), .err_single(f_s), .err_double(f_d));

  ecc_ram #(.ECC_MODE(1)) u_enc (
    .clk(clk), .rst(rst), .wr_en(e_we), .wr_addr(e_wa), .wr_data(e_wd),
    .inj_single(e_is), .inj_double(e_id), .rd_en(e_re), .rd_addr(e_ra),
    .rd_data(e_q), .err_single(e_s), .err_double(e_d));

  ecc_ram #(.ECC_MODE(2)) u_dec (
    .clk(clk), .rst(rst), .wr_en(d_we), .wr_addr(d_wa), .wr_data(d_wd),
    .inj_single(d_is), .inj_double(d_id), .rd_en(d_re), .rd_addr(d_ra),
    .rd_data(d_q), .err_single(d_s), .err_double(d_d));

  ecc_ram #(.ECC_MODE(0)) u_off (
    .clk(clk), .rst(rst), .wr_en(o_we), .wr_addr(o_wa), .wr_data(o_wd),
    .inj_single(o_is), .inj_double(o_id), .rd_en(o_re), .rd_addr(o_ra),
    .rd_data(o_q), .err_single(o_s), .err_double(o_d));

  task automatic chk(input bit ok, input string req, input logic [143:0] act,
                     input logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic f_wr(input int a, input logic [127:0] d, input bit s, input bit db);
    @(negedge clk);
    f_we = 1; f_wa = 5'(a); f_wd = d; f_is = s; f_id = db;
    @(negedge clk);
    f_we = 0; f_is = 0; f_id = 0;
  endtask

  task automatic f_rd(input int a);
    @(negedge clk);
    f_re = 1; f_ra = 5'(a);
    @(negedge clk);
    f_re = 0;
  endtask

  task automatic e_wr(input int a, input logic [127:0] d, input bit s, input bit db);
    @(negedge clk);
    e_we = 1; e_wa = 5'(a); e_wd = d; e_is = s; e_id = db;
    @(negedge clk);
    e_we = 0; e_is = 0; e_id = 0;
  endtask

  task automatic e_rd(input int a);
    @(negedge clk);
    e_re = 1; e_ra = 5'(a);
    @(negedge clk);
    e_re = 0;
  endtask

  task automatic d_wr(input int a, input logic [143:0] w);
    @(negedge clk);
    d_we = 1; d_wa = 5'(a); d_wd = w;
    @(negedge clk);
    d_we = 0;
  endtask

  task automatic d_rd(input int a);
    @(negedge clk);
    d_re = 1; d_ra = 5'(a);
    @(negedge clk);
    d_re = 0;
  endtask

  task automatic test_reset_state();
    chk(f_q == '0 && !f_s && !f_d, "R11 reset full", {f_s, f_d, f_q}, '0);
    chk(e_q == '0, "R11 reset enc", e_q, '0);
  endtask

  task automatic test_clean();
    logic [127:0] a = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    logic [127:0] b = 128'hffff_0000_a5a5_5a5a_8000_0000_0000_0001;
    f_wr(1, a, 0, 0);
    f_wr(4, b, 0, 0);
    f_rd(1);
    chk(f_q == a && !f_s && !f_d, "R1 clean read A", {f_s, f_d, f_q}, {2'b00, a});
    f_rd(4);
    chk(f_q == b && !f_s && !f_d, "R1 clean read B", {f_s, f_d, f_q}, {2'b00, b});
  endtask

  task automatic test_inj_single();
    logic [127:0] a = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    f_wr(2, a, 1, 0);
    f_rd(2);
    chk(f_q == a && f_s && !f_d, "R6 R3 single corrected", {f_s, f_d, f_q}, {2'b10, a});
    f_rd(2);
    chk(f_s && !f_d, "R8 error persists in array", {f_s, f_d}, 2'b10);
  endtask

  task automatic test_inj_double();
    logic [127:0] a = 128'hdead_beef_0000_1111_cafe_f00d_0000_00f0;
    f_wr(3, a, 0, 1);
    f_rd(3);
    chk(f_q == (a ^ 128'h3) && f_d && !f_s, "R4 double raw",
        {f_s, f_d, f_q}, {2'b01, a ^ 128'h3});
    f_wr(6, a, 1, 1);
    f_rd(6);
    chk(f_q == (a ^ 128'h3) && f_d && !f_s, "R7 double wins",
        {f_s, f_d, f_q}, {2'b01, a ^ 128'h3});
  endtask

  task automatic test_read_timing();
    logic [127:0] a = 128'haaaa;
    logic [127:0] b = 128'hbbbb;
    f_wr(5, a, 0, 0);
    @(negedge clk);
    f_we = 1; f_wa = 5'd5; f_wd = b; f_re = 1; f_ra = 5'd5;
    @(negedge clk);
    f_we = 0; f_re = 0;
    chk(f_q == a, "R5 read-first", f_q, a);
    f_ra = 5'd1;
    repeat (3) @(negedge clk);
    chk(f_q == a, "R5 hold while idle", f_q, a);
    f_rd(5);
    chk(f_q == b, "R5 new data", f_q, b);
  endtask

  task automatic test_reset_keeps();
    logic [127:0] a = 128'h7777_0000_1234_5678;
    f_wr(7, a, 0, 0);
    f_rd(7);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(f_q == '0 && !f_s && !f_d, "R11 reset clears output", f_q, '0);
    f_rd(7);
    chk(f_q == a, "R11 memory kept", f_q, a);
  endtask

  task automatic test_encode_only();
    e_wr(0, '0, 0, 0);
    e_rd(0);
    chk(e_q == '0 && !e_s && !e_d, "R10 enc zero word", e_q, '0);
    e_wr(1, {64'd2, 64'd1}, 0, 0);
    e_rd(1);
    chk(e_q == {8'h85, 64'd2, 8'h83, 64'd1}, "R2 R1 check bytes", e_q,
        {8'h85, 64'd2, 8'h83, 64'd1});
    e_wr(2, {64'd2, 64'd1}, 1, 0);
    e_rd(2);
    chk(e_q == {8'h85, 64'd2, 8'h83, 64'd0} && !e_s && !e_d, "R6 R10 enc raw inj",
        e_q, {8'h85, 64'd2, 8'h83, 64'd0});
  endtask

  task automatic test_roundtrip();
    logic [143:0] w;
    logic [63:0]  pat [3];
    int           pos1 [6];
    pat[0] = 64'h0123_4567_89ab_cdef;
    pat[1] = 64'hffff_ffff_ffff_ffff;
    pat[2] = 64'h8000_0000_0000_0001;
    pos1[0] = 0; pos1[1] = 37; pos1[2] = 63;
    pos1[3] = 64; pos1[4] = 70; pos1[5] = 71;
    for (int k = 0; k < 3; k++) begin
      e_wr(10, {~pat[k], pat[k]}, 0, 0);
      e_rd(10);
      w = e_q;
      d_wr(11, w);
      d_rd(11);
      chk(d_q == {~pat[k], pat[k]} && !d_s && !d_d, "R2 encode-decode clean",
          {d_s, d_d, d_q}, {2'b00, ~pat[k], pat[k]});
      for (int m = 0; m < 6; m++) begin
        d_wr(12, w ^ (144'd1 << pos1[m]));
        d_rd(12);
        chk(d_q == {~pat[k], pat[k]} && d_s && !d_d, "R3 single any position",
            {d_s, d_d, d_q}, {2'b10, ~pat[k], pat[k]});
      end
      d_wr(13, w ^ (144'd1 << 5) ^ (144'd1 << 66));
      d_rd(13);
      chk(d_q == {~pat[k], pat[k] ^ 64'h20} && d_d && !d_s, "R4 data+check double",
          {d_s, d_d, d_q}, {2'b01, ~pat[k], pat[k] ^ 64'h20});
      // R9: lane 1 single only
      d_wr(14, w ^ (144'd1 << 100));
      d_rd(14);
      chk(d_q == {~pat[k], pat[k]} && d_s && !d_d, "R9 lane1 single",
          {d_s, d_d, d_q}, {2'b10, ~pat[k], pat[k]});
      // R9: lane 0 double, lane 1 single
      d_wr(15, w ^ 144'h3 ^ (144'd1 << 80));
      d_rd(15);
      chk(d_s && d_d && d_q == {~pat[k], pat[k] ^ 64'h3}, "R9 both flags OR",
          {d_s, d_d, d_q}, {2'b11, ~pat[k], pat[k] ^ 64'h3});
    end
  endtask

  task automatic test_off();
    logic [127:0] a = 128'h5555_aaaa_0f0f_f0f0_1234_0000_9999_0003;
    @(negedge clk);
    o_we = 1; o_wa = 5'd9; o_wd = a; o_is = 1; o_id = 1;
    @(negedge clk);
    o_we = 0; o_is = 0; o_id = 0; o_re = 1; o_ra = 5'd9;
    @(negedge clk);
    o_re = 0;
    chk(o_q == a && !o_s && !o_d, "R10 off mode ignores injection",
        {o_s, o_d, o_q}, {2'b00, a});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    test_reset_state();
    test_clean();
    test_inj_single();
    test_inj_double();
    test_read_timing();
    test_reset_keeps();
    test_encode_only();
    test_roundtrip();
    test_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule